// File: doc/BRIEF.md
# Exhaustive Low-Weight Error Pattern Generator

This block produces test stimulus for a cyclic-code decoder. A pulse on `start_i` captures a code vector. The block then walks through every error pattern of weight one, two and three over the `N` bit positions of that vector. For each pattern it presents the code vector XOR-ed with the pattern as one beat of a valid/ready stream. Each beat carries a tag that gives the number of flipped bits.

Single-bit patterns come first, then the two-bit patterns, then the three-bit patterns. Within a group, the set bit positions (p0 < p1 < p2) run in ascending lexicographic order, so the mask bits sweep from the least significant end toward the most significant end. No pattern is repeated and none is left out.

A downstream decoder accepts beats at its own pace. After the final three-bit pattern is taken, the block raises a one-cycle completion pulse and goes idle. It stays idle until the next start.

Top module: `epg_top`

## Requirements
- R1: While reset is active and after it is released, until the first start, `valid_o` and `done_o` are 0 and `weight_o` reads 0.
- R2: One complete run covers every pattern exactly once. For N=23 it gives 23 weight-1, 253 weight-2 and 1771 weight-3 beats; for N=31 it gives 31, 465 and 4495.
- R3: `weight_o` is 1, 2 or 3 for every beat. Within a run it never decreases: all weight-1 beats come before any weight-2 beat, and all weight-2 beats come before any weight-3 beat.
- R4: Within one weight, patterns are ordered by their bit positions (p0, p1, p2) with p0 < p1 < p2, in ascending lexicographic order. The first pattern of the run sets bit 0 only, and the last pattern sets bits N-3, N-2 and N-1.
- R5: Each beat carries `word_o` equal to the captured code vector XOR the pattern, so exactly `weight_o` bits differ from the code vector.
- R6: While `valid_o` is 1 and `ready_i` is 0, `word_o` and `weight_o` hold their values into the next cycle.
- R7: The pattern advances only on a clock edge where `valid_o` and `ready_i` are both 1. Idle cycles of `ready_i` do not skip or repeat any pattern.
- R8: `done_o` is 1 for exactly one cycle, the cycle right after the final weight-3 beat is accepted. In that cycle and afterwards, `valid_o` is 0.
- R9: A start captures `code_i` and restarts at the first weight-1 pattern in the next cycle, even if a run is in progress. Start takes priority over a beat accepted in the same cycle.
- R10: Changes on `code_i` outside a start cycle have no effect on the words produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture `code_i` and begin a new run |
| code_i | input | N | Code vector to corrupt |
| ready_i | input | 1 | Downstream accepts the current beat |
| valid_o | output | 1 | A corrupted word is presented |
| word_o | output | N | Code vector XOR current error pattern |
| weight_o | output | 2 | Number of flipped bits (0 when idle) |
| done_o | output | 1 | One-cycle pulse after the last pattern is accepted |

## Verification
The properties assume that `start_i` is a single-cycle pulse: a held start would keep restarting the run, and the hold check excludes start cycles. They also assume that `ready_i` changes only between clock edges. The bench drives start for exactly one cycle and changes `ready_i` and `code_i` only at the falling edge. It also scrambles `code_i` right after every start, so any leak of the live input into the output words would show up. Backpressure follows fixed 8-cycle ready masks that include long stalls and back-to-back accepts, so holding, advancing and the end-of-run pulse are all exercised.

// File: rtl/epg_pkg.sv
package epg_pkg;

   typedef enum logic [1:0] {
      WT_NONE  = 2'd0,
      WT_ONE   = 2'd1,
      WT_TWO   = 2'd2,
      WT_THREE = 2'd3
   } weight_e;

   function automatic int idx_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction

endpackage

// File: rtl/epg_walker.sv
module epg_walker
   import epg_pkg::*;
#(
   parameter int N  = 23,
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   output weight_e       weight_o,
   output logic [IW-1:0] pos_a_o,
   output logic [IW-1:0] pos_b_o,
   output logic [IW-1:0] pos_c_o,
   output logic          last_o
);

   localparam logic [IW-1:0] TOP1 = IW'(N - 1);
   localparam logic [IW-1:0] TOP2 = IW'(N - 2);
   localparam logic [IW-1:0] TOP3 = IW'(N - 3);
   localparam logic [IW-1:0] ONE  = IW'(1);
   localparam logic [IW-1:0] TWO  = IW'(2);
   localparam logic [IW-1:0] THR  = IW'(3);

   weight_e       wt_q;
   logic [IW-1:0] a_q, b_q, c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wt_q <= WT_ONE;
         a_q  <= '0;
         b_q  <= ONE;
         c_q  <= TWO;
      end else if (load_i) begin
         wt_q <= WT_ONE;
         a_q  <= '0;
         b_q  <= ONE;
         c_q  <= TWO;
      end else if (step_i) begin
         unique case (wt_q)
            WT_ONE: begin
               if (a_q != TOP1) begin
                  a_q <= a_q + ONE;
               end else begin
                  wt_q <= WT_TWO;
                  a_q  <= '0;
                  b_q  <= ONE;
               end
            end
            WT_TWO: begin
               if (b_q != TOP1) begin
                  b_q <= b_q + ONE;
               end else if (a_q != TOP2) begin
                  a_q <= a_q + ONE;
                  b_q <= a_q + TWO;
               end else begin
                  wt_q <= WT_THREE;
                  a_q  <= '0;
                  b_q  <= ONE;
                  c_q  <= TWO;
               end
            end
            WT_THREE: begin
               if (c_q != TOP1) begin
                  c_q <= c_q + ONE;
               end else if (b_q != TOP2) begin
                  b_q <= b_q + ONE;
                  c_q <= b_q + TWO;
               end else if (a_q != TOP3) begin
                  a_q <= a_q + ONE;
                  b_q <= a_q + TWO;
                  c_q <= a_q + THR;
               end
            end
            default: wt_q <= WT_ONE;
         endcase
      end
   end

   assign weight_o = wt_q;
   assign pos_a_o  = a_q;
   assign pos_b_o  = b_q;
   assign pos_c_o  = c_q;
   assign last_o   = (wt_q == WT_THREE) && (a_q == TOP3);

endmodule

// File: rtl/epg_mask.sv
module epg_mask
   import epg_pkg::*;
#(
   parameter int N  = 23,
   parameter int IW = 5
) (
   input  weight_e       weight_i,
   input  logic [IW-1:0] pos_a_i,
   input  logic [IW-1:0] pos_b_i,
   input  logic [IW-1:0] pos_c_i,
   output logic [N-1:0]  mask_o
);

   logic use_b, use_c;

   assign use_b = (weight_i == WT_TWO) || (weight_i == WT_THREE);
   assign use_c = (weight_i == WT_THREE);

   for (genvar k = 0; k < N; k++) begin : g_bit
      assign mask_o[k] = (pos_a_i == IW'(k))
                       | (use_b && (pos_b_i == IW'(k)))
                       | (use_c && (pos_c_i == IW'(k)));
   end

endmodule

// File: rtl/epg_top.sv
module epg_top
   import epg_pkg::*;
#(
   parameter int N = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [N-1:0] code_i,
   input  logic         ready_i,
   output logic         valid_o,
   output logic [N-1:0] word_o,
   output logic [1:0]   weight_o,
   output logic         done_o
);

   localparam int IW = idx_bits(N);

   if (N < 4) begin : g_bad_len
      $error("epg_top: N must be at least 4");
   end
   if (N > (1 << IW)) begin : g_bad_iw
      $error("epg_top: index width too small for N");
   end

   logic          busy_q, done_q;
   logic [N-1:0]  cv_q;
   logic          accept, step, last;
   weight_e       wt;
   logic [IW-1:0] pa, pb, pc;
   logic [N-1:0]  mask;

   assign accept = busy_q && ready_i;
   assign step   = accept && !start_i;

   epg_walker #(.N(N), .IW(IW)) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .step_i   (step),
      .weight_o (wt),
      .pos_a_o  (pa),
      .pos_b_o  (pb),
      .pos_c_o  (pc),
      .last_o   (last)
   );

   epg_mask #(.N(N), .IW(IW)) u_mask (
      .weight_i (wt),
      .pos_a_i  (pa),
      .pos_b_i  (pb),
      .pos_c_i  (pc),
      .mask_o   (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cv_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            cv_q   <= code_i;
            busy_q <= 1'b1;
         end else if (step && last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign valid_o  = busy_q;
   assign word_o   = cv_q ^ mask;
   assign weight_o = busy_q ? wt : WT_NONE;
   assign done_o   = done_q;

endmodule

// File: rtl/epg_top_chk.sv
module epg_top_chk #(
   parameter int N = 23
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         ready_i,
   input logic         valid_o,
   input logic [N-1:0] word_o,
   input logic [1:0]   weight_o,
   input logic         done_o,
   input logic [N-1:0] cv_q
);

   // R6
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i && !start_i) |=>
         (valid_o && $stable(word_o) && $stable(weight_o)));

   // R3
   tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (weight_o != 2'd0));

   // R3
   tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && !start_i) |=> (!valid_o || (weight_o >= $past(weight_o))));

   // R5
   flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($countones(word_o ^ cv_q) == int'(weight_o)));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && (weight_o == 2'd1) && ((word_o ^ cv_q) == N'(1))));

endmodule

bind epg_top epg_top_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .ready_i  (ready_i),
   .valid_o  (valid_o),
   .word_o   (word_o),
   .weight_o (weight_o),
   .done_o   (done_o),
   .cv_q     (cv_q)
);

// File: tb/test_epg_top.sv
module test_epg_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        a_start = 0, a_ready = 0;
   logic [22:0] a_code = '0;
   logic        a_valid, a_done;
   logic [22:0] a_word;
   logic [1:0]  a_wt;

   logic        b_start = 0, b_ready = 0;
   logic [30:0] b_code = '0;
   logic        b_valid, b_done;
   logic [30:0] b_word;
   logic [1:0]  b_wt;

   epg_top #(.N(23)) i_epg_top (
      .clk(clk), .rst_n(rst_n), .start_i(a_start), .code_i(a_code),
      .ready_i(a_ready), .valid_o(a_valid), .word_o(a_word),
      .weight_o(a_wt), .done_o(a_done));

   epg_top #(.N(31)) i_epg_top_w31 (
      .clk(clk), .rst_n(rst_n), .start_i(b_start), .code_i(b_code),
      .ready_i(b_ready), .valid_o(b_valid), .word_o(b_word),
      .weight_o(b_wt), .done_o(b_done));

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   localparam logic [22:0] CV_TAB [0:2] = '{23'h000000, 23'h5A3C71, 23'h7FFFFF};
   localparam logic [7:0]  RDY_TAB[0:2] = '{8'hFF, 8'b1010_0110, 8'b0001_0011};

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pmask(input int w, input int a, input int b, input int c);
      logic [31:0] m;
      m = 32'(1) << a;
      if (w >= 2) m |= 32'(1) << b;
      if (w == 3) m |= 32'(1) << c;
      return m;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 150000);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // Runs a complete pass on one instance (sel 0: N=23, sel 1: N=31)
   task automatic full_run(input int sel, input logic [31:0] cv, input logic [7:0] rp,
                           input int e1, input int e2, input int e3);
      int n = (sel == 0) ? 23 : 31;
      int ew = 1, ea = 0, eb = 1, ec = 2;
      int cnt[4] = '{0, 0, 0, 0};
      int bad_word = 0, bad_tag = 0, stall_bad = 0, k = 0;
      bit ended = 0, seen_done = 0, pv = 0, pr = 0;
      logic [31:0] pw = '0, word;
      logic [1:0]  pt = '0, wt;
      logic        vld, dn, rdy;
      @(negedge clk);
      if (sel == 0) begin a_start = 1; a_code = cv[22:0]; end
      else          begin b_start = 1; b_code = cv[30:0]; end
      @(negedge clk);
      // R10: scramble the live input after the start cycle
      if (sel == 0) begin a_start = 0; a_code = ~cv[22:0]; end
      else          begin b_start = 0; b_code = ~cv[30:0]; end
      while (k < 30000) begin
         vld  = (sel == 0) ? a_valid : b_valid;
         dn   = (sel == 0) ? a_done  : b_done;
         word = (sel == 0) ? 32'(a_word) : 32'(b_word);
         wt   = (sel == 0) ? a_wt : b_wt;
         if (pv && !pr && (word != pw || wt != pt)) stall_bad++;
         if (dn) begin
            seen_done = 1;
            check(!vld, "R8", "valid low with done", 64'(vld), 0);
            break;
         end
         if (vld) begin
            if (word != (cv ^ pmask(ew, ea, eb, ec))) bad_word++;
            if (int'(wt) != ew) bad_tag++;
         end
         rdy = rp[k % 8];
         if (sel == 0) a_ready = rdy; else b_ready = rdy;
         k++;
         if (vld && rdy) begin
            if (ended) bad_word++;
            cnt[ew]++;
            if (ew == 1) begin
               if (ea < n - 1) ea++;
               else begin ew = 2; ea = 0; eb = 1; end
            end else if (ew == 2) begin
               if (eb < n - 1) eb++;
               else if (ea < n - 2) begin ea++; eb = ea + 1; end
               else begin ew = 3; ea = 0; eb = 1; ec = 2; end
            end else begin
               if (ec < n - 1) ec++;
               else if (eb < n - 2) begin eb++; ec = eb + 1; end
               else if (ea < n - 3) begin ea++; eb = ea + 1; ec = eb + 1; end
               else ended = 1;
            end
         end
         pv = vld; pr = rdy; pw = word; pt = wt;
         @(negedge clk);
      end
      check(cnt[1] == e1, "R2", "weight-1 beats", cnt[1], e1);
      check(cnt[2] == e2, "R2", "weight-2 beats", cnt[2], e2);
      check(cnt[3] == e3, "R2", "weight-3 beats", cnt[3], e3);
      check(bad_word == 0, "R4 R5 R7 R10", "word mismatches", bad_word, 0);
      check(bad_tag == 0, "R3", "tag mismatches", bad_tag, 0);
      check(stall_bad == 0, "R6", "changes during stall", stall_bad, 0);
      check(seen_done && ended, "R8", "done after final beat",
            64'(seen_done) + 2 * 64'(ended), 3);
      @(negedge clk);
      dn  = (sel == 0) ? a_done : b_done;
      vld = (sel == 0) ? a_valid : b_valid;
      check(!dn && !vld, "R8", "done single cycle, idle after",
            64'(dn) + 2 * 64'(vld), 0);
      if (sel == 0) a_ready = 0; else b_ready = 0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!a_valid && !a_done && a_wt == 0, "R1", "outputs in reset",
            64'(a_valid) + 2 * 64'(a_done) + 4 * 64'(a_wt), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check(!a_valid && !a_done && a_wt == 0, "R1", "outputs idle after reset",
            64'(a_valid) + 2 * 64'(a_done) + 4 * 64'(a_wt), 0);
      check(!b_valid && !b_done, "R1", "wide instance idle",
            64'(b_valid) + 2 * 64'(b_done), 0);

      // Table walk on the N=23 instance: R2 R3 R4 R5 R6 R7 R8 R10
      for (int t = 0; t < 3; t++)
         full_run(0, 32'(CV_TAB[t]), RDY_TAB[t], 23, 253, 1771);

      // N=31 instance: R2
      full_run(1, 32'h2BAD_F00D & 32'h7FFF_FFFF, 8'hFF, 31, 465, 4495);

      // R9: restart in the middle of a run, start and ready in the same cycle
      @(negedge clk);
      a_start = 1; a_code = 23'h123456;
      @(negedge clk);
      a_start = 0; a_ready = 1;
      repeat (40) @(negedge clk);
      check(a_wt == 2, "R9", "mid-run weight before restart", a_wt, 2);
      a_start = 1; a_code = 23'h0F0F0F;
      @(negedge clk);
      a_start = 0; a_ready = 0;
      check(a_valid && a_wt == 1, "R9", "restart tag", a_wt, 1);
      check(a_word == (23'h0F0F0F ^ 23'h1), "R9", "restart first word",
            a_word, 23'h0F0F0F ^ 23'h1);
      repeat (3) @(negedge clk);
      check(a_word == (23'h0F0F0F ^ 23'h1), "R6", "hold without ready",
            a_word, 23'h0F0F0F ^ 23'h1);
      a_ready = 1;
      @(negedge clk);
      a_ready = 0;
      check(a_word == (23'h0F0F0F ^ 23'h2), "R7", "single accept advances one",
            a_word, 23'h0F0F0F ^ 23'h2);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule